// File: doc/BRIEF.md
# Polled Rotary Encoder Delay Control

This block turns a hand-turned rotary encoder into a coarse desired-delay value for an audio delay line. The encoder's contacts are assumed to be debounced already outside the block. Both encoder lines first pass through a synchronizer. The block looks at them only on one audio frame out of every `POLL_FRAMES` (64 by default). At 44.1 kHz that is about one look every 1.5 ms. When the first line (A) is found low on such a frame, a detent has occurred. The level of the second line (B) then tells which way the knob turned.

The result is a 16-bit delay, counted in sample words. Its low byte is always zero. Each detent adds or removes 256 words, which is roughly 6 ms of delay. A sticky "edge seen" flag makes sure that one low period of line A gives exactly one step, however many polls see it low. Another stage elsewhere slews the actual delay toward this value. That stage is outside the block.

Top module: `enc_delay_ctrl`

## Requirements
- R1: After reset, `desired_delay` is 0x0000, the edge-seen flag is clear and the frame counter holds 64. The first poll therefore falls on the 64th `frame_stb` pulse after reset.
- R2: The encoder is looked at only on every 64th `frame_stb` pulse. On every other frame, and on every cycle where `frame_stb` is low, `desired_delay` stays unchanged whatever the encoder lines do.
- R3: If the synchronized line A is high at a poll, the edge-seen flag clears and `desired_delay` does not change.
- R4: If the synchronized line A is low at a poll and the edge-seen flag is already set, `desired_delay` does not change.
- R5: If the synchronized line A is low at a poll, the flag is clear and line B is low, the flag sets and the high byte of `desired_delay` increases by one (+0x0100). The update is visible after the clock edge that samples the poll frame's strobe.
- R6: If the synchronized line A is low at a poll, the flag is clear and line B is high, the flag sets and the high byte of `desired_delay` decreases by one (-0x0100).
- R7: Bits [7:0] of `desired_delay` are always zero.
- R8: The high byte wraps modulo 256 without saturating. A step down from 0x0000 gives 0xFF00, and a step up from 0xFF00 gives 0x0000.
- R9: Lines A and B each pass through two flip-flops before they are used. A change applied in the same cycle as the poll strobe is not seen by that poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| enc_a | input | 1 | Encoder line A (its falling level marks a detent) |
| enc_b | input | 1 | Encoder line B (direction: low = up, high = down) |
| desired_delay | output | 16 | Desired delay in sample words; low byte always zero |

## Verification
A frame counter that drifts by one shows up as a step on the wrong frame. The step then lands one pulse early or late against a count of 64 frames from reset. A stuck edge-seen flag shows up within two polls: either a second step appears while A is held low, or no step appears after A returns high and goes low again. A wrong direction or step size shows in the delay word right after the first poll that steps. Likewise, a synchronizer with too few stages shows as a step on a poll whose line change arrived only in the strobe cycle.

// File: rtl/enc_delay_pkg.sv
package enc_delay_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic a;
        logic b;
    } enc_lines_t;

    // Decide the step for one poll from the synchronized lines and the sticky flag.
    function automatic step_e pick_step(enc_lines_t lines, logic seen);
        if (lines.a || seen) begin
            return STEP_NONE;
        end
        return lines.b ? STEP_DOWN : STEP_UP;
    endfunction

    // Next value of the sticky flag at a poll.
    function automatic logic next_seen(enc_lines_t lines, logic seen);
        return lines.a ? 1'b0 : 1'b1 | seen;
    endfunction

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '1;
                    else     chain_q[s] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '1;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int POLL_FRAMES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    output logic poll_o
);
    localparam int CW = $clog2(POLL_FRAMES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(POLL_FRAMES);
    localparam logic [CW-1:0] LAST   = CW'(1);

    logic [CW-1:0] cnt_q;

    assign poll_o = frame_stb && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RELOAD;
        end else if (frame_stb) begin
            if (cnt_q == LAST) cnt_q <= RELOAD;
            else               cnt_q <= cnt_q - LAST;
        end
    end
endmodule

// File: rtl/detent_detect.sv
module detent_detect
    import enc_delay_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       poll_i,
    input  enc_lines_t lines_i,
    output step_e      step_o,
    output logic       seen_o
);
    logic seen_q;

    assign seen_o = seen_q;
    assign step_o = poll_i ? pick_step(lines_i, seen_q) : STEP_NONE;

    always_ff @(posedge clk) begin
        if (rst)         seen_q <= 1'b0;
        else if (poll_i) seen_q <= next_seen(lines_i, seen_q);
    end
endmodule

// File: rtl/delay_accum.sv
module delay_accum
    import enc_delay_pkg::*;
#(
    parameter int DW         = 16,
    parameter int STEP_SHIFT = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  step_e         step_i,
    output logic [DW-1:0] delay_o
);
    localparam int HW = DW - STEP_SHIFT;
    localparam logic [HW-1:0] ONE = HW'(1);

    logic [HW-1:0] coarse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q <= '0;
        end else begin
            unique case (step_i)
                STEP_UP:   coarse_q <= coarse_q + ONE;
                STEP_DOWN: coarse_q <= coarse_q - ONE;
                default:   coarse_q <= coarse_q;
            endcase
        end
    end

    assign delay_o = {coarse_q, {STEP_SHIFT{1'b0}}};
endmodule

// File: rtl/enc_delay_ctrl.sv
module enc_delay_ctrl
    import enc_delay_pkg::*;
#(
    parameter int DELAY_W     = 16,
    parameter int STEP_SHIFT  = 8,
    parameter int POLL_FRAMES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_stb,
    input  logic               enc_a,
    input  logic               enc_b,
    output logic [DELAY_W-1:0] desired_delay
);
    localparam int LINES_W = $bits(enc_lines_t);

    enc_lines_t raw_lines;
    enc_lines_t sync_lines;
    logic       poll_w;
    logic       seen_w;
    step_e      step_w;

    assign raw_lines.a = enc_a;
    assign raw_lines.b = enc_b;

    enc_sync #(.W(LINES_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_lines),
        .q_o (sync_lines)
    );

    poll_timer #(.POLL_FRAMES(POLL_FRAMES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .poll_o    (poll_w)
    );

    detent_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .poll_i  (poll_w),
        .lines_i (sync_lines),
        .step_o  (step_w),
        .seen_o  (seen_w)
    );

    delay_accum #(.DW(DELAY_W), .STEP_SHIFT(STEP_SHIFT)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_w),
        .delay_o (desired_delay)
    );
endmodule

// File: rtl/enc_delay_chk.sv
module enc_delay_chk #(
    parameter int DW         = 16,
    parameter int STEP_SHIFT = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_stb,
    input logic [DW-1:0] desired_delay,
    input logic          poll,
    input logic          flag,
    input logic          a_s,
    input logic          b_s
);
    localparam logic [DW-1:0] STEP = DW'(1) << STEP_SHIFT;

    p_reset_r1: assert property (@(posedge clk) rst |=> desired_delay == '0);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(desired_delay));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (poll && a_s) |=> (!flag && $stable(desired_delay)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (poll && !a_s && flag) |=> $stable(desired_delay));

    p_up_r5: assert property (@(posedge clk) disable iff (rst)
        (poll && !a_s && !flag && !b_s) |=> (flag && desired_delay == $past(desired_delay) + STEP));

    p_down_r6: assert property (@(posedge clk) disable iff (rst)
        (poll && !a_s && !flag && b_s) |=> (flag && desired_delay == $past(desired_delay) - STEP));

    p_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
        desired_delay[STEP_SHIFT-1:0] == '0);
endmodule

bind enc_delay_ctrl enc_delay_chk #(.DW(DELAY_W), .STEP_SHIFT(STEP_SHIFT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_stb     (frame_stb),
    .desired_delay (desired_delay),
    .poll          (poll_w),
    .flag          (seen_w),
    .a_s           (sync_lines.a),
    .b_s           (sync_lines.b)
);

// File: tb/sim_enc_delay_ctrl.sv
module sim_enc_delay_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int POLL_N     = 64;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic        enc_a = 1'b1;
    logic        enc_b = 1'b1;
    logic [15:0] desired_delay;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    item_t sb_q[$];

    // reference model state
    int       m_cnt  = POLL_N;
    bit       m_seen = 0;
    bit [7:0] m_hi   = 8'h00;
    bit       eff_a  = 1;
    bit       eff_b  = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_delay_ctrl u0 (
        .clk           (clk),
        .rst           (rst),
        .frame_stb     (frame_stb),
        .enc_a         (enc_a),
        .enc_b         (enc_b),
        .desired_delay (desired_delay)
    );

    // monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (desired_delay !== it.exp) begin
                bad++;
                $display("FAIL %s: desired_delay=%h expected=%h", it.tag, desired_delay, it.exp);
            end
        end
    end

    task automatic model_frame();
        if (m_cnt == 1) begin
            m_cnt = POLL_N;
            if (eff_a) m_seen = 0;
            else if (!m_seen) begin
                m_seen = 1;
                if (eff_b) m_hi = m_hi - 8'd1;
                else       m_hi = m_hi + 8'd1;
            end
        end else begin
            m_cnt--;
        end
    endtask

    task automatic one_frame(string tag, bit late, bit la, bit lb);
        item_t it;
        @(negedge clk);
        frame_stb = 1'b1;
        if (late) begin
            enc_a = la;
            enc_b = lb;
        end
        @(posedge clk);
        #1;
        frame_stb = 1'b0;
        model_frame();
        it.exp = {m_hi, 8'h00};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic set_lines(bit a, bit b);
        @(negedge clk);
        enc_a = a;
        enc_b = b;
        repeat (3) @(posedge clk);
        #1;
        eff_a = a;
        eff_b = b;
    endtask

    // 63 quiet frames tagged R2, then the poll frame with its own tag
    task automatic poll_cycle(string tag);
        for (int i = 0; i < POLL_N - 1; i++) one_frame("R2", 0, 0, 0);
        one_frame(tag, 0, 0, 0);
    endtask

    task automatic detent(bit b, string tag);
        set_lines(1, b);
        poll_cycle("R3");
        set_lines(0, b);
        poll_cycle(tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!ended) begin
            ended = 1;
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (desired_delay !== 16'h0000) begin
            bad++;
            $display("FAIL R1: desired_delay=%h expected=0000", desired_delay);
        end

        // R1: first poll falls on the 64th pulse; R5 step up
        set_lines(0, 0);
        poll_cycle("R5");
        // R4: A still low, flag set, no step
        poll_cycle("R4");
        // R3: A high clears flag, no step
        set_lines(1, 0);
        poll_cycle("R3");
        // R6: step down back to zero
        set_lines(0, 1);
        poll_cycle("R6");
        // R8: wrap below zero, then back up
        detent(1, "R8");
        detent(0, "R8");
        // R9: change arrives only in the strobe cycle of a poll
        set_lines(1, 1);
        for (int i = 0; i < POLL_N - 1; i++) one_frame("R2", 0, 0, 0);
        one_frame("R9", 1, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        eff_a = 0;
        eff_b = 0;
        poll_cycle("R9");
        // R7: several up steps, low byte stays zero
        for (int k = 0; k < 3; k++) detent(0, "R7");
        // R2: frame_stb low with lines toggling
        set_lines(0, 1);
        set_lines(1, 0);
        repeat (4) @(negedge clk);
        total++;
        if (desired_delay !== {m_hi, 8'h00}) begin
            bad++;
            $display("FAIL R2: desired_delay=%h expected=%h", desired_delay, {m_hi, 8'h00});
        end

        repeat (3) @(posedge clk);
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule